// File: doc/BRIEF.md
# Addressed Serial Register Control Port

This block is the slave end of a four-wire serial control link. A host drives an active-low latch, a serial clock and a data line, and reads back on a data-out line with its own output enable. Through this link the host reads and writes a byte-wide internal register space by way of a simple synchronous register bus. The bus has an address, write data, a write strobe, a read strobe and read data returned one cycle after the read strobe.

The port powers up passive. It joins serial control only after the latch has been pulsed low three times. After that, every latch-low window is one transaction. The first byte carries a 7-bit device address and a direction bit. The next two bytes give a 16-bit starting location, upper byte first. Data bytes follow until the latch rises, and the location steps by one after each complete byte. A pin selects the low bit of the device address, so two ports can share one latch line.

All serial inputs are synchronized into the system clock. The system clock must run at least four times faster than the serial clock.

Top module: `spi_regport`

## Requirements
- R1: After reset the data-out enable is 0, the serial-mode flag is 0, and neither bus strobe is asserted.
- R2: The serial-mode flag rises only after the third rising edge of the latch. No transaction that ends before that point causes any bus access, and once set the flag stays set until reset.
- R3: Byte 0 is sent MSB first. Bits [7:1] are the device address and bit 0 is the direction (1 = read, 0 = write). If the address does not match, the rest of the transaction causes no bus access and the data-out enable stays 0.
- R4: The expected device address is 7'b0000000 when `dev_sel` is 0 and 7'b0000001 when `dev_sel` is 1.
- R5: Bytes 1 and 2 form the 16-bit location, upper byte first. In a write, the first data byte (byte 3, MSB first) appears on the bus with that location in a single-cycle write strobe.
- R6: In a write burst, each further complete data byte is written to the next location, and the location wraps from 16'hFFFF to 16'h0000.
- R7: A data byte cut short by the latch rising is never written.
- R8: In a read, the data-out enable stays 0 through bytes 0 to 2. It is 1 from the first falling serial-clock edge of byte 3, and each data bit, MSB first, is valid before the following rising edge.
- R9: In a read burst, each successive data byte is the content of the next consecutive location.
- R10: The data-out enable returns to 0 once the latch rises.
- R11: The write and read strobes are never asserted together, and each one lasts one clock cycle per byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| dev_sel | input | 1 | Selects device address bit 0 |
| ser_latch_n | input | 1 | Active-low transaction latch (asynchronous) |
| ser_clk | input | 1 | Serial clock (asynchronous) |
| ser_din | input | 1 | Serial data from host |
| ser_dout | output | 1 | Serial data to host |
| ser_dout_en | output | 1 | Drive enable for ser_dout; 0 means high impedance |
| ser_mode | output | 1 | Serial control mode active |
| bus_addr | output | 16 | Register bus location |
| bus_wdata | output | 8 | Register bus write data |
| bus_we | output | 1 | Single-cycle write strobe |
| bus_re | output | 1 | Single-cycle read strobe |
| bus_rdata | input | 8 | Read data, valid the cycle after bus_re |

## Verification
The bench builds the block with its default parameters: three mode-entry pulses, a two-stage synchronizer and a 6-bit upper device-address field of zero. With these defaults, both `dev_sel` settings give addresses that a test can hit or deliberately miss. The serial clock runs at one tenth of the system clock, so the synchronizer delay and the one-cycle read latency of the bus both fall inside a half serial period. This lets the test observe the timing of the first driven read bit. Because the 16-bit location is full width, a burst that starts at 16'hFFFE reaches the wrap to zero.

// File: rtl/spi_regport_pkg.sv
package spi_regport_pkg;
  localparam int LOC_W  = 16;
  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_HDR,
    PH_LOC_HI,
    PH_LOC_LO,
    PH_DATA,
    PH_SKIP
  } phase_t;
endpackage

// File: rtl/spi_regport_sync.sv
module spi_regport_sync #(
  parameter int          W      = 3,
  parameter int          STAGES = 2,
  parameter logic [W-1:0] INIT  = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q,
  output logic [W-1:0] q_prev
);
  logic [W-1:0] stg [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) stg[s] <= INIT;
        else if (s == 0) stg[s] <= d;
        else stg[s] <= stg[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) q_prev <= INIT;
    else q_prev <= stg[STAGES-1];
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/spi_regport_mode.sv
module spi_regport_mode #(
  parameter int PULSES = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic latch_rise,
  output logic in_mode
);
  localparam int CW = $clog2(PULSES + 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      in_mode <= 1'b0;
    end else if (!in_mode && latch_rise) begin
      if (cnt == CW'(PULSES - 1)) in_mode <= 1'b1;
      cnt <= cnt + 1'b1;
    end
  end

  assert_mode_sticky_R2: assert property (@(posedge clk) disable iff (rst)
    in_mode |=> in_mode);
  assert_mode_needs_rise_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(in_mode) |-> $past(latch_rise));
endmodule

// File: rtl/spi_regport_engine.sv
module spi_regport_engine
  import spi_regport_pkg::*;
#(
  parameter logic [5:0] DEV_HI = 6'd0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_mode,
  input  logic              dev_sel,
  input  logic              latch_fall,
  input  logic              latch_rise,
  input  logic              clk_rise,
  input  logic              clk_fall,
  input  logic              din,
  output logic              dout,
  output logic              dout_en,
  output logic [LOC_W-1:0]  bus_addr,
  output logic [BYTE_W-1:0] bus_wdata,
  output logic              bus_we,
  output logic              bus_re,
  input  logic [BYTE_W-1:0] bus_rdata
);
  phase_t              phase;
  logic [2:0]          bitcnt;
  logic [BYTE_W-1:0]   shreg;
  logic [BYTE_W-1:0]   nxt;
  logic [BYTE_W-2:0]   txsh;
  logic [LOC_W-1:0]    loc;
  logic                is_rd;
  logic [6:0]          my_addr;

  assign nxt     = {shreg[BYTE_W-2:0], din};
  assign my_addr = {DEV_HI, dev_sel};

  always_ff @(posedge clk) begin
    if (rst) begin
      phase     <= PH_IDLE;
      bitcnt    <= '0;
      shreg     <= '0;
      txsh      <= '0;
      loc       <= '0;
      is_rd     <= 1'b0;
      dout      <= 1'b0;
      dout_en   <= 1'b0;
      bus_addr  <= '0;
      bus_wdata <= '0;
      bus_we    <= 1'b0;
      bus_re    <= 1'b0;
    end else begin
      bus_we <= 1'b0;
      bus_re <= 1'b0;
      if (latch_rise) begin
        phase   <= PH_IDLE;
        dout_en <= 1'b0;
      end else if (latch_fall && in_mode) begin
        phase   <= PH_HDR;
        bitcnt  <= '0;
        is_rd   <= 1'b0;
        dout_en <= 1'b0;
      end else if (clk_rise && phase != PH_IDLE && phase != PH_SKIP) begin
        shreg  <= nxt;
        bitcnt <= bitcnt + 1'b1;
        if (bitcnt == 3'd7) begin
          unique case (phase)
            PH_HDR: begin
              if (nxt[7:1] == my_addr) begin
                is_rd <= nxt[0];
                phase <= PH_LOC_HI;
              end else begin
                phase <= PH_SKIP;
              end
            end
            PH_LOC_HI: begin
              loc[LOC_W-1:BYTE_W] <= nxt;
              phase               <= PH_LOC_LO;
            end
            PH_LOC_LO: begin
              loc   <= {loc[LOC_W-1:BYTE_W], nxt};
              phase <= PH_DATA;
              if (is_rd) begin
                bus_addr <= {loc[LOC_W-1:BYTE_W], nxt};
                bus_re   <= 1'b1;
              end
            end
            PH_DATA: begin
              loc <= loc + 1'b1;
              if (is_rd) begin
                bus_addr <= loc + 1'b1;
                bus_re   <= 1'b1;
              end else begin
                bus_addr  <= loc;
                bus_wdata <= nxt;
                bus_we    <= 1'b1;
              end
            end
            default: ;
          endcase
        end
      end else if (clk_fall && phase == PH_DATA && is_rd) begin
        dout_en <= 1'b1;
        if (bitcnt == 3'd0) begin
          dout <= bus_rdata[BYTE_W-1];
          txsh <= bus_rdata[BYTE_W-2:0];
        end else begin
          dout <= txsh[BYTE_W-2];
          txsh <= {txsh[BYTE_W-3:0], 1'b0};
        end
      end
    end
  end

  assert_strobe_excl_R11: assert property (@(posedge clk) disable iff (rst)
    !(bus_we && bus_re));
  assert_we_pulse_R11: assert property (@(posedge clk) disable iff (rst)
    bus_we |=> !bus_we);
  assert_re_pulse_R11: assert property (@(posedge clk) disable iff (rst)
    bus_re |=> !bus_re);
  assert_drive_only_read_R8: assert property (@(posedge clk) disable iff (rst)
    dout_en |-> (phase == PH_DATA && is_rd));
  assert_release_on_latch_R10: assert property (@(posedge clk) disable iff (rst)
    latch_rise |=> !dout_en);
  assert_no_access_outside_mode_R2: assert property (@(posedge clk) disable iff (rst)
    !in_mode |-> !(bus_we || bus_re));
  assert_skip_silent_R3: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_SKIP) |-> !(bus_we || dout_en));
endmodule

// File: rtl/spi_regport.sv
module spi_regport
  import spi_regport_pkg::*;
#(
  parameter int         MODE_PULSES = 3,
  parameter int         SYNC_STAGES = 2,
  parameter logic [5:0] DEV_HI      = 6'd0
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        dev_sel,
  input  logic        ser_latch_n,
  input  logic        ser_clk,
  input  logic        ser_din,
  output logic        ser_dout,
  output logic        ser_dout_en,
  output logic        ser_mode,
  output logic [15:0] bus_addr,
  output logic [7:0]  bus_wdata,
  output logic        bus_we,
  output logic        bus_re,
  input  logic [7:0]  bus_rdata
);
  logic [2:0] s_q, s_prev;
  logic       latch_rise, latch_fall, clk_rise, clk_fall;

  spi_regport_sync #(.W(3), .STAGES(SYNC_STAGES), .INIT(3'b010)) u_sync (
    .clk    (clk),
    .rst    (rst),
    .d      ({ser_din, ser_latch_n, ser_clk}),
    .q      (s_q),
    .q_prev (s_prev)
  );

  assign clk_rise   =  s_q[0] && !s_prev[0];
  assign clk_fall   = !s_q[0] &&  s_prev[0];
  assign latch_rise =  s_q[1] && !s_prev[1];
  assign latch_fall = !s_q[1] &&  s_prev[1];

  spi_regport_mode #(.PULSES(MODE_PULSES)) u_mode (
    .clk        (clk),
    .rst        (rst),
    .latch_rise (latch_rise),
    .in_mode    (ser_mode)
  );

  spi_regport_engine #(.DEV_HI(DEV_HI)) u_engine (
    .clk        (clk),
    .rst        (rst),
    .in_mode    (ser_mode),
    .dev_sel    (dev_sel),
    .latch_fall (latch_fall),
    .latch_rise (latch_rise),
    .clk_rise   (clk_rise),
    .clk_fall   (clk_fall),
    .din        (s_q[2]),
    .dout       (ser_dout),
    .dout_en    (ser_dout_en),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_we     (bus_we),
    .bus_re     (bus_re),
    .bus_rdata  (bus_rdata)
  );
endmodule

// File: tb/spi_regport_bench.sv
module spi_regport_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        dev_sel = 1'b0;
  logic        ser_latch_n = 1'b1;
  logic        ser_clk = 1'b0;
  logic        ser_din = 1'b0;
  logic        ser_dout, ser_dout_en, ser_mode;
  logic [15:0] bus_addr;
  logic [7:0]  bus_wdata, bus_rdata;
  logic        bus_we, bus_re;

  int checks = 0;
  int errors = 0;

  logic [7:0]  mem     [256];
  logic [7:0]  exp_mem [256];
  logic [15:0] wlog    [64];
  int          wcount = 0;
  int          we_len = 0;
  int          we_bad = 0;
  logic [7:0]  tx_buf  [8];
  logic [7:0]  rx_buf  [8];
  logic        oe_early, oe_data_ok;

  always #2 clk = ~clk;

  spi_regport u_spi_regport (
    .clk(clk), .rst(rst), .dev_sel(dev_sel),
    .ser_latch_n(ser_latch_n), .ser_clk(ser_clk), .ser_din(ser_din),
    .ser_dout(ser_dout), .ser_dout_en(ser_dout_en), .ser_mode(ser_mode),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_we(bus_we),
    .bus_re(bus_re), .bus_rdata(bus_rdata)
  );

  always_ff @(posedge clk) begin
    if (bus_we) begin
      mem[bus_addr[7:0]] <= bus_wdata;
      if (wcount < 64) wlog[wcount] <= bus_addr;
      wcount <= wcount + 1;
    end
    if (bus_re) bus_rdata <= mem[bus_addr[7:0]];
    if (bus_we && bus_re) we_bad <= we_bad + 1;
    we_len <= bus_we ? we_len + 1 : 0;
    if (bus_we && we_len > 0) we_bad <= we_bad + 1;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bits(input logic [7:0] tx, input int nbits,
                           output logic [7:0] rx, output logic oe_any, output logic oe_all);
    rx = '0; oe_any = 1'b0; oe_all = 1'b1;
    for (int i = 7; i >= 8 - nbits; i--) begin
      ser_din = tx[i];
      wait_clk(5);
      rx[i] = ser_dout;
      oe_any |= ser_dout_en;
      oe_all &= ser_dout_en;
      ser_clk = 1'b1;
      wait_clk(5);
      ser_clk = 1'b0;
    end
  endtask

  task automatic latch_low();
    ser_latch_n = 1'b0;
    wait_clk(5);
  endtask

  task automatic latch_high();
    wait_clk(5);
    ser_latch_n = 1'b1;
    wait_clk(10);
  endtask

  task automatic do_write(input logic [6:0] dev, input logic [15:0] loc,
                          input int n, input int tail_bits);
    logic [7:0] r; logic a, b;
    latch_low();
    send_bits({dev, 1'b0}, 8, r, a, b);
    send_bits(loc[15:8], 8, r, a, b);
    send_bits(loc[7:0], 8, r, a, b);
    for (int k = 0; k < n; k++) send_bits(tx_buf[k], 8, r, a, b);
    if (tail_bits > 0) send_bits(8'h5A, tail_bits, r, a, b);
    latch_high();
  endtask

  task automatic do_read(input logic [6:0] dev, input logic [15:0] loc, input int n);
    logic [7:0] r; logic a, b;
    oe_early = 1'b0; oe_data_ok = 1'b1;
    latch_low();
    send_bits({dev, 1'b1}, 8, r, a, b); oe_early |= a;
    send_bits(loc[15:8], 8, r, a, b);   oe_early |= a;
    send_bits(loc[7:0], 8, r, a, b);    oe_early |= a;
    for (int k = 0; k < n; k++) begin
      send_bits(8'h00, 8, rx_buf[k], a, b);
      oe_data_ok &= b;
    end
    latch_high();
  endtask

  initial begin
    int base, n, w0;
    void'($urandom(32'h5EED1234));
    for (int i = 0; i < 256; i++) begin
      mem[i] = 8'h00; exp_mem[i] = 8'h00;
    end
    wait_clk(4);
    rst = 1'b0;
    wait_clk(2);
    check(ser_dout_en == 1'b0, "R1 oe", ser_dout_en, 0);
    check(ser_mode == 1'b0, "R1 mode", ser_mode, 0);
    check(!bus_we && !bus_re, "R1 strobes", {bus_we, bus_re}, 0);

    tx_buf[0] = 8'h77;
    do_write(7'd0, 16'h0010, 1, 0);
    check(wcount == 0, "R2 write before mode", wcount, 0);
    check(ser_mode == 1'b0, "R2 mode after pulse 1", ser_mode, 0);
    latch_low(); latch_high();
    check(ser_mode == 1'b0, "R2 mode after pulse 2", ser_mode, 0);
    latch_low(); latch_high();
    check(ser_mode == 1'b1, "R2 mode after pulse 3", ser_mode, 1);

    tx_buf[0] = 8'hA5;
    do_write(7'd0, 16'h1234, 1, 0);
    exp_mem[8'h34] = 8'hA5;
    check(wcount == 1, "R5 single write count", wcount, 1);
    check(wlog[0] == 16'h1234, "R5 write location", wlog[0], 16'h1234);
    check(mem[8'h34] == 8'hA5, "R5 write data", mem[8'h34], 8'hA5);
    check(we_bad == 0, "R11 strobe shape", we_bad, 0);

    tx_buf[0] = 8'h11; tx_buf[1] = 8'h22; tx_buf[2] = 8'h33;
    w0 = wcount;
    do_write(7'd0, 16'hFFFE, 3, 0);
    exp_mem[8'hFE] = 8'h11; exp_mem[8'hFF] = 8'h22; exp_mem[8'h00] = 8'h33;
    check(wcount == w0 + 3, "R6 burst count", wcount, w0 + 3);
    check(wlog[w0] == 16'hFFFE, "R6 burst loc0", wlog[w0], 16'hFFFE);
    check(wlog[w0+1] == 16'hFFFF, "R6 burst loc1", wlog[w0+1], 16'hFFFF);
    check(wlog[w0+2] == 16'h0000, "R6 burst wrap", wlog[w0+2], 16'h0000);

    w0 = wcount;
    tx_buf[0] = 8'h99;
    do_write(7'd1, 16'h0040, 1, 0);
    check(wcount == w0, "R3 mismatched write ignored", wcount, w0);
    do_read(7'd1, 16'h0034, 2);
    check(!oe_early && !oe_data_ok, "R3 mismatched read undriven", oe_data_ok, 0);

    dev_sel = 1'b1;
    w0 = wcount;
    do_write(7'd0, 16'h0041, 1, 0);
    check(wcount == w0, "R4 addr 0 ignored with sel=1", wcount, w0);
    tx_buf[0] = 8'h3C;
    do_write(7'd1, 16'h0042, 1, 0);
    exp_mem[8'h42] = 8'h3C;
    check(wcount == w0 + 1 && mem[8'h42] == 8'h3C, "R4 addr 1 with sel=1", mem[8'h42], 8'h3C);
    dev_sel = 1'b0;

    w0 = wcount;
    tx_buf[0] = 8'hC3;
    do_write(7'd0, 16'h0050, 1, 5);
    exp_mem[8'h50] = 8'hC3;
    check(wcount == w0 + 1, "R7 partial byte dropped", wcount, w0 + 1);
    check(mem[8'h51] == 8'h00, "R7 next location untouched", mem[8'h51], 0);

    do_read(7'd0, 16'hFFFE, 3);
    check(!oe_early, "R8 undriven in bytes 0-2", oe_early, 0);
    check(oe_data_ok, "R8 driven in data bytes", oe_data_ok, 1);
    check(rx_buf[0] == exp_mem[8'hFE], "R8 first read byte", rx_buf[0], exp_mem[8'hFE]);
    check(rx_buf[1] == exp_mem[8'hFF], "R9 burst read byte 1", rx_buf[1], exp_mem[8'hFF]);
    check(rx_buf[2] == exp_mem[8'h00], "R9 burst read wrap", rx_buf[2], exp_mem[8'h00]);
    check(ser_dout_en == 1'b0, "R10 released after latch", ser_dout_en, 0);

    for (int t = 0; t < 16; t++) begin
      base = 32'h80 + ($urandom % 64);
      n = 1 + ($urandom % 4);
      for (int k = 0; k < n; k++) begin
        tx_buf[k] = 8'($urandom);
        exp_mem[8'(base + k)] = tx_buf[k];
      end
      do_write(7'd0, 16'(base), n, 0);
      do_read(7'd0, 16'(base), n);
      for (int k = 0; k < n; k++)
        check(rx_buf[k] == exp_mem[8'(base + k)], "R9 random readback",
              rx_buf[k], exp_mem[8'(base + k)]);
      check(ser_dout_en == 1'b0, "R10 random release", ser_dout_en, 0);
    end
    check(we_bad == 0, "R11 strobes single-cycle and exclusive", we_bad, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 4);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule